// File: doc/BRIEF.md
# Square Block Isometry Generator

This block takes one square block of pixels, SIDE pixels on a side, as a raster stream and holds it in local storage. It then plays the stored block back eight times. Each playback reads the storage through a different address mapping from the symmetry group of the square, so one stored block gives eight candidate blocks that are related by geometry. Downstream matching logic receives each candidate as a raster stream. Every beat carries a 3-bit code that names the mapping and a flag that marks the final pixel of the candidate.

Pixel values go through unchanged. Only the order in which storage is read differs between the eight playbacks. The block sits between a memory that supplies shrunk blocks and an array that compares candidates against target blocks. It accepts no new block until the eighth playback has been fully consumed. Both edges use a valid/ready handshake, so the downstream side can stall the playback at any beat.

Top module: `sq_iso_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, `in_ready` is 1 and `out_valid` is 0.
- R2: In the load phase, the block captures one pixel on each cycle where `in_valid` and `in_ready` are both high, in raster order (row-major, index = row*SIDE+col). In the cycle after the SIDE*SIDE-th pixel is accepted, `in_ready` is 0 and `out_valid` is 1.
- R3: `in_ready` stays 0 from the end of the load until the final beat of the candidate with code 7 is accepted. In the next cycle `in_ready` is 1 again.
- R4: `in_ready` and `out_valid` are never both 1 in the same cycle.
- R5: Candidates are emitted with `out_code` rising from 0 to 7. Each candidate lasts exactly SIDE*SIDE accepted beats, and the first beat after a load carries code 0.
- R6: At output raster position (r,c), with M = SIDE-1, the emitted pixel is the stored pixel at (row,col) given by the code as follows:
  - 0: (r,c)
  - 1: (M-c,r)
  - 2: (M-r,M-c)
  - 3: (c,M-r)
  - 4: (r,M-c)
  - 5: (M-r,c)
  - 6: (c,r)
  - 7: (M-c,M-r)
- R7: `out_last` is 1 exactly on the beat for output position (M,M) of each candidate.
- R8: While `out_valid` is 1 and `out_ready` is 0, the block keeps `out_pix`, `out_code` and `out_last` unchanged and does not advance.
- R9: Pixels presented on `in_pix` with `in_valid` high while `in_ready` is 0 are ignored. The stored block, and so every playback, stays intact across all eight candidates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input pixel is present |
| in_pix | input | PIX_W | Input pixel, raster order |
| in_ready | output | 1 | Block accepts an input pixel |
| out_valid | output | 1 | Output pixel is present |
| out_pix | output | PIX_W | Output pixel of the current candidate |
| out_code | output | 3 | Mapping code of the current candidate |
| out_last | output | 1 | Final pixel of the current candidate |
| out_ready | input | 1 | Downstream accepts the output pixel |

## Verification
A wrong row or column counter shows up in the same cycle. The read address points at the wrong stored pixel, so `out_pix` mismatches on the next compared beat, and `out_last` lands off position (M,M). A wrong phase or code register shows up as `in_ready` opening early or late, or as a skipped or repeated code, within one candidate length. A write that slips in during playback changes the stored block. It therefore surfaces as a pixel mismatch at the first later beat that reads the corrupted location, and the bench drives junk input on every replay cycle so that such a path is exercised.

// File: rtl/sq_iso_pkg.sv
package sq_iso_pkg;

    typedef enum logic {
        PH_LOAD = 1'b0,
        PH_PLAY = 1'b1
    } phase_e;

    localparam int NUM_ISO = 8;
    localparam int CODE_W  = 3;

    // Source row for output position (r,c) under a given mapping code.
    function automatic int src_row(input int code, input int side, input int r, input int c);
        int m;
        m = side - 1;
        case (code)
            0:       src_row = r;
            1:       src_row = m - c;
            2:       src_row = m - r;
            3:       src_row = c;
            4:       src_row = r;
            5:       src_row = m - r;
            6:       src_row = c;
            default: src_row = m - c;
        endcase
    endfunction

    // Source column for output position (r,c) under a given mapping code.
    function automatic int src_col(input int code, input int side, input int r, input int c);
        int m;
        m = side - 1;
        case (code)
            0:       src_col = c;
            1:       src_col = r;
            2:       src_col = m - c;
            3:       src_col = m - r;
            4:       src_col = m - c;
            5:       src_col = c;
            6:       src_col = r;
            default: src_col = m - r;
        endcase
    endfunction

endpackage

// File: rtl/sq_iso_store.sv
module sq_iso_store #(
    parameter int DEPTH = 16,
    parameter int PIX_W = 8,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PIX_W-1:0] wr_pix,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PIX_W-1:0] rd_pix
);

    logic [PIX_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_idx] <= wr_pix;
        end
    end

    assign rd_pix = cells[rd_idx];

endmodule

// File: rtl/sq_iso_addr.sv
module sq_iso_addr
    import sq_iso_pkg::*;
#(
    parameter int SIDE  = 4,
    parameter int CRD_W = 2,
    parameter int IDX_W = 4
) (
    input  logic [CODE_W-1:0] code,
    input  logic [CRD_W-1:0]  row,
    input  logic [CRD_W-1:0]  col,
    output logic [IDX_W-1:0]  rd_idx
);

    logic [IDX_W-1:0] cand [NUM_ISO];

    // One address candidate per mapping; the code selects among them.
    for (genvar g = 0; g < NUM_ISO; g++) begin : g_map
        assign cand[g] = IDX_W'(src_row(g, SIDE, int'(row), int'(col)) * SIDE
                              + src_col(g, SIDE, int'(row), int'(col)));
    end

    assign rd_idx = cand[code];

endmodule

// File: rtl/sq_iso_ctrl.sv
module sq_iso_ctrl
    import sq_iso_pkg::*;
#(
    parameter int SIDE  = 4,
    parameter int CRD_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              out_ready,
    output logic              in_ready,
    output logic              out_valid,
    output logic              wr_en,
    output logic              at_end,
    output logic [CRD_W-1:0]  row,
    output logic [CRD_W-1:0]  col,
    output logic [CODE_W-1:0] code
);

    localparam logic [CRD_W-1:0]  EDGE     = CRD_W'(SIDE - 1);
    localparam logic [CODE_W-1:0] LAST_ISO = CODE_W'(NUM_ISO - 1);

    typedef struct packed {
        phase_e             ph;
        logic [CRD_W-1:0]   row;
        logic [CRD_W-1:0]   col;
        logic [CODE_W-1:0]  code;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic  step;

    always_comb begin
        s_d    = s_q;
        at_end = (s_q.row == EDGE) && (s_q.col == EDGE);
        step   = (s_q.ph == PH_LOAD) ? in_valid : out_ready;
        if (step) begin
            if (s_q.col == EDGE) begin
                s_d.col = '0;
                if (s_q.row == EDGE) begin
                    s_d.row = '0;
                    if (s_q.ph == PH_LOAD) begin
                        s_d.ph   = PH_PLAY;
                        s_d.code = '0;
                    end else if (s_q.code == LAST_ISO) begin
                        s_d.ph   = PH_LOAD;
                        s_d.code = '0;
                    end else begin
                        s_d.code = s_q.code + 1'b1;
                    end
                end else begin
                    s_d.row = s_q.row + 1'b1;
                end
            end else begin
                s_d.col = s_q.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_LOAD, row: '0, col: '0, code: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready  = (s_q.ph == PH_LOAD);
    assign out_valid = (s_q.ph == PH_PLAY);
    assign wr_en     = in_ready && in_valid;
    assign row       = s_q.row;
    assign col       = s_q.col;
    assign code      = s_q.code;

endmodule

// File: rtl/sq_iso_gen.sv
module sq_iso_gen
    import sq_iso_pkg::*;
#(
    parameter int SIDE  = 4,
    parameter int PIX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_pix,
    output logic              in_ready,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_pix,
    output logic [CODE_W-1:0] out_code,
    output logic              out_last,
    input  logic              out_ready
);

    localparam int DEPTH = SIDE * SIDE;
    localparam int CRD_W = (SIDE > 1) ? $clog2(SIDE) : 1;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic             wr_en;
    logic             at_end;
    logic [CRD_W-1:0] row;
    logic [CRD_W-1:0] col;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;

    sq_iso_ctrl #(.SIDE(SIDE), .CRD_W(CRD_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .wr_en     (wr_en),
        .at_end    (at_end),
        .row       (row),
        .col       (col),
        .code      (out_code)
    );

    assign wr_idx = IDX_W'(int'(row) * SIDE + int'(col));

    sq_iso_addr #(.SIDE(SIDE), .CRD_W(CRD_W), .IDX_W(IDX_W)) u_addr (
        .code   (out_code),
        .row    (row),
        .col    (col),
        .rd_idx (rd_idx)
    );

    sq_iso_store #(.DEPTH(DEPTH), .PIX_W(PIX_W), .IDX_W(IDX_W)) u_store (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_pix (in_pix),
        .rd_idx (rd_idx),
        .rd_pix (out_pix)
    );

    assign out_last = out_valid && at_end;

endmodule

// File: rtl/sq_iso_chk.sv
module sq_iso_chk #(
    parameter int PIX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_pix,
    input logic [2:0]       out_code,
    input logic             out_last,
    input logic             out_ready
);

    assert_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)
                                       && $stable(out_code) && $stable(out_last)));

    assert_code_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last && out_code != 3'd7)
        |=> (out_valid && out_code == $past(out_code) + 3'd1));

    assert_first_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_code == 3'd0));

    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last && out_code == 3'd7) |=> (in_ready && !out_valid));

    assert_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !(out_ready && out_last && out_code == 3'd7)) |=> !in_ready);

endmodule

bind sq_iso_gen sq_iso_chk #(.PIX_W(PIX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_pix   (out_pix),
    .out_code  (out_code),
    .out_last  (out_last),
    .out_ready (out_ready)
);

// File: tb/tb_sq_iso_gen.sv
`timescale 1ns/1ps
module tb_sq_iso_gen;

    localparam int SIDE  = 4;
    localparam int PIX_W = 8;
    localparam int NPIX  = SIDE * SIDE;
    localparam int RUN   = 3000;
    localparam int LIMIT = 20000;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid;
    logic [PIX_W-1:0] in_pix;
    logic             in_ready;
    logic             out_valid;
    logic [PIX_W-1:0] out_pix;
    logic [2:0]       out_code;
    logic             out_last;
    logic             out_ready;

    sq_iso_gen #(.SIDE(SIDE), .PIX_W(PIX_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_pix    (in_pix),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_pix   (out_pix),
        .out_code  (out_code),
        .out_last  (out_last),
        .out_ready (out_ready)
    );

    always #2 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // Behavioural reference: captured block plus phase, position and code.
    int blk [NPIX];
    int m_load = 1;
    int m_pos  = 0;
    int m_code = 0;
    int blocks_played = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_load = 1; m_pos = 0; m_code = 0;
        end else if (m_load != 0) begin
            if (in_valid) begin
                blk[m_pos] = int'(in_pix);
                m_pos++;
                if (m_pos == NPIX) begin
                    m_pos = 0; m_load = 0; m_code = 0;
                end
            end
        end else if (out_ready) begin
            m_pos++;
            if (m_pos == NPIX) begin
                m_pos = 0;
                if (m_code == 7) begin
                    m_load = 1;
                    blocks_played++;
                end else begin
                    m_code++;
                end
            end
        end
    end

    function automatic int ref_pix(int code, int pos);
        int r, c, m, sr, sc;
        r = pos / SIDE; c = pos % SIDE; m = SIDE - 1;
        case (code)
            0: begin sr = r;     sc = c;     end
            1: begin sr = m - c; sc = r;     end
            2: begin sr = m - r; sc = m - c; end
            3: begin sr = c;     sc = m - r; end
            4: begin sr = r;     sc = m - c; end
            5: begin sr = m - r; sc = c;     end
            6: begin sr = c;     sc = r;     end
            default: begin sr = m - c; sc = m - r; end
        endcase
        return blk[sr * SIDE + sc];
    endfunction

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    logic             prev_stall;
    logic [PIX_W-1:0] prev_pix;
    logic [2:0]       prev_code;

    task automatic compare_all();
        check("R3 in_ready", int'(in_ready), (m_load != 0) ? 1 : 0);
        check("R2 out_valid", int'(out_valid), (m_load != 0) ? 0 : 1);
        check("R4 exclusive handshake", int'(in_ready && out_valid), 0);
        if (m_load == 0) begin
            check("R5 out_code", int'(out_code), m_code);
            check("R6 pixel (R9 junk input ignored)", int'(out_pix), ref_pix(m_code, m_pos));
            check("R7 out_last", int'(out_last), (m_pos == NPIX - 1) ? 1 : 0);
        end
        if (prev_stall) begin
            check("R8 held pixel", int'(out_pix), int'(prev_pix));
            check("R8 held code", int'(out_code), int'(prev_code));
        end
    endtask

    initial begin
        int seq;
        rst_n = 1'b0; in_valid = 1'b0; in_pix = '0; out_ready = 1'b0;
        prev_stall = 1'b0; prev_pix = '0; prev_code = '0;
        seq = 0;
        repeat (3) @(negedge clk);
        check("R1 reset in_ready", int'(in_ready), 1);
        check("R1 reset out_valid", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-reset in_ready", int'(in_ready), 1);
        check("R1 post-reset out_valid", int'(out_valid), 0);
        for (int cyc = 0; cyc < RUN; cyc++) begin
            if (cyc != 0) @(negedge clk);
            compare_all();
            if (cyc < 400) begin
                // Free flowing, ramp pixels.
                in_valid  = 1'b1;
                in_pix    = PIX_W'(seq); seq++;
                out_ready = 1'b1;
            end else if (cyc < 1700) begin
                // Random gaps on both sides.
                in_valid  = ($urandom_range(0, 9) < 7);
                in_pix    = PIX_W'($urandom);
                out_ready = ($urandom_range(0, 9) < 6);
            end else begin
                // Heavy stalls, input always offered (junk during replay, R9).
                in_valid  = 1'b1;
                in_pix    = PIX_W'($urandom);
                out_ready = ($urandom_range(0, 9) < 3);
            end
            prev_stall = out_valid && !out_ready;
            prev_pix   = out_pix;
            prev_code  = out_code;
        end
        check("R5 several blocks replayed", (blocks_played >= 4) ? 1 : 0, 1);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", LIMIT, RUN);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule